// File: doc/BRIEF.md
# Exception Priority Mask Filter

This block decides, for a single pending exception, whether the current masking state lets it preempt. It holds three masking registers: a one-bit primary mask that silences everything except the non-maskable interrupt and the hard fault, a one-bit fault mask that silences everything except the non-maskable interrupt, and a base-priority threshold. When the threshold is nonzero, it blocks any exception whose priority value is numerically equal to or above the threshold, because a larger value means lower urgency.

The requester presents a valid flag, the exception number, a two-bit class and a priority value. The `allow` result is purely combinational from the register contents and the request. The masks are written through a small select/data port that only takes effect at privileged level. A combinational read-back port returns any of them. Arbitration among several pending exceptions and vector fetching are handled elsewhere.

Top module: `exc_mask_filter`

## Requirements
- R1: After reset, the primary mask, the fault mask and the base-priority threshold are all 0, and no masking applies.
- R2: A valid request of class 0 (non-maskable interrupt) is always allowed, whatever any of the three masks hold.
- R3: While the primary mask is 1, requests of class 2 (other fault) and class 3 (interrupt) are blocked. Class 1 (hard fault) is not affected by the primary mask.
- R4: While the fault mask is 1, every valid request other than class 0 is blocked, including class 1.
- R5: While the threshold is nonzero, a request of class 1, 2 or 3 whose priority value is greater than or equal to the threshold is blocked. One with a smaller priority value is not blocked by the threshold.
- R6: A threshold of 0 applies no priority masking, for every priority value including 0.
- R7: A write with `priv_lvl` = 0 (user level) changes none of the three registers.
- R8: A privileged write with `wr_sel` 0 loads bit 0 of `wr_data` into the primary mask, and one with `wr_sel` 1 loads bit 0 into the fault mask. `wr_sel` 2 loads all of `wr_data` into the threshold, and `wr_sel` 3 changes nothing. The new value is visible from the cycle after the clock edge that accepts the write.
- R9: `rd_data` returns, in the same cycle, the primary mask for `rd_sel` 0 and the fault mask for `rd_sel` 1, each zero-extended. It returns the threshold for `rd_sel` 2 and zero for `rd_sel` 3.
- R10: `allow` follows the request inputs in the same cycle, and it is 0 whenever `req_valid` is 0.
- R11: `pass_num` equals `req_num` when `allow` is 1 and is zero otherwise.
- R12: The mask outputs `pri_mask`, `flt_mask` and `base_pri` always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A pending exception is presented |
| req_num | input | NUM_W (9) | Number of the pending exception |
| req_cls | input | 2 | Class: 0 NMI, 1 hard fault, 2 other fault, 3 interrupt |
| req_prio | input | PRIO_W (8) | Priority value, smaller is more urgent |
| wr_en | input | 1 | Mask register write strobe |
| priv_lvl | input | 1 | 1 = privileged, 0 = user level |
| wr_sel | input | 2 | Write target: 0 primary, 1 fault, 2 threshold, 3 none |
| wr_data | input | PRIO_W (8) | Write value |
| rd_sel | input | 2 | Read-back select, same encoding as wr_sel |
| rd_data | output | PRIO_W (8) | Read-back value |
| allow | output | 1 | Pending exception may preempt |
| pass_num | output | NUM_W (9) | req_num when allowed, else 0 |
| pri_mask | output | 1 | Current primary mask |
| flt_mask | output | 1 | Current fault mask |
| base_pri | output | PRIO_W (8) | Current base-priority threshold |

## Verification
A wrong mask register shows up at the ports one cycle after the write that corrupted it. It appears on the mask outputs and the read-back port at once, and on `allow` at the first request of an affected class. The bench therefore runs every request against a shadow of the three registers that it updates itself. It mixes privileged and user writes so that a register which takes a write it should have ignored causes a mismatch on the next request or read. The comparator's edges are exercised directly: priority equal to the threshold, one below it, and a threshold of zero.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;

    typedef enum logic [1:0] {
        CLS_NMI   = 2'd0,
        CLS_HARD  = 2'd1,
        CLS_FAULT = 2'd2,
        CLS_IRQ   = 2'd3
    } exc_cls_e;

    typedef enum logic [1:0] {
        SEL_PRI  = 2'd0,
        SEL_FLT  = 2'd1,
        SEL_BASE = 2'd2,
        SEL_NONE = 2'd3
    } mask_sel_e;

    localparam int unsigned MAX_PRIO_W = 9;

endpackage

// File: rtl/exc_mask_regs.sv
module exc_mask_regs
    import exc_mask_pkg::*;
#(
    parameter int unsigned PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              priv_lvl,
    input  logic [1:0]        wr_sel,
    input  logic [PRIO_W-1:0] wr_data,
    output logic              pm_q,
    output logic              fm_q,
    output logic [PRIO_W-1:0] bp_q
);

    typedef struct packed {
        logic              pm;
        logic              fm;
        logic [PRIO_W-1:0] bp;
    } mask_state_t;

    localparam mask_state_t RESET_STATE = '{pm: 1'b0, fm: 1'b0, bp: '0};

    mask_state_t state_d, state_q;
    logic        wr_ok;
    mask_sel_e   sel;

    assign sel   = mask_sel_e'(wr_sel);
    assign wr_ok = wr_en & priv_lvl;

    always_comb begin
        state_d = state_q;
        if (wr_ok) begin
            unique case (sel)
                SEL_PRI:  state_d.pm = wr_data[0];
                SEL_FLT:  state_d.fm = wr_data[0];
                SEL_BASE: state_d.bp = wr_data;
                default:  state_d    = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign pm_q = state_q.pm;
    assign fm_q = state_q.fm;
    assign bp_q = state_q.bp;

endmodule

// File: rtl/exc_prio_gate.sv
module exc_prio_gate #(
    parameter int unsigned PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] thresh,
    input  logic [PRIO_W-1:0] prio,
    output logic              prio_blocked
);

    logic thresh_active;
    logic at_or_below;

    assign thresh_active = |thresh;

    generate
        if (PRIO_W == 1) begin : g_narrow
            // a one-bit threshold is active only at 1, so only prio 1 matches
            assign at_or_below = prio[0];
        end else begin : g_wide
            assign at_or_below = (prio >= thresh);
        end
    endgenerate

    assign prio_blocked = thresh_active & at_or_below;

endmodule

// File: rtl/exc_readback.sv
module exc_readback
    import exc_mask_pkg::*;
#(
    parameter int unsigned PRIO_W = 8
) (
    input  logic [1:0]        rd_sel,
    input  logic              pm,
    input  logic              fm,
    input  logic [PRIO_W-1:0] bp,
    output logic [PRIO_W-1:0] rd_data
);

    localparam int unsigned PAD_W = PRIO_W - 1;

    logic [PRIO_W-1:0] pm_ext, fm_ext;

    generate
        if (PAD_W == 0) begin : g_nopad
            assign pm_ext = pm;
            assign fm_ext = fm;
        end else begin : g_pad
            assign pm_ext = {{PAD_W{1'b0}}, pm};
            assign fm_ext = {{PAD_W{1'b0}}, fm};
        end
    endgenerate

    always_comb begin
        unique case (mask_sel_e'(rd_sel))
            SEL_PRI:  rd_data = pm_ext;
            SEL_FLT:  rd_data = fm_ext;
            SEL_BASE: rd_data = bp;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
    import exc_mask_pkg::*;
#(
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned NUM_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NUM_W-1:0]  req_num,
    input  logic [1:0]        req_cls,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              wr_en,
    input  logic              priv_lvl,
    input  logic [1:0]        wr_sel,
    input  logic [PRIO_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [PRIO_W-1:0] rd_data,
    output logic              allow,
    output logic [NUM_W-1:0]  pass_num,
    output logic              pri_mask,
    output logic              flt_mask,
    output logic [PRIO_W-1:0] base_pri
);

    initial begin
        if (PRIO_W < 1 || PRIO_W > MAX_PRIO_W) begin
            $error("exc_mask_filter: PRIO_W out of range");
        end
    end

    logic              pm_q, fm_q;
    logic [PRIO_W-1:0] bp_q;
    logic              prio_blocked;
    logic              allow_d;
    exc_cls_e          cls;

    assign cls = exc_cls_e'(req_cls);

    exc_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .priv_lvl (priv_lvl),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .pm_q     (pm_q),
        .fm_q     (fm_q),
        .bp_q     (bp_q)
    );

    exc_prio_gate #(.PRIO_W(PRIO_W)) u_gate (
        .thresh       (bp_q),
        .prio         (req_prio),
        .prio_blocked (prio_blocked)
    );

    exc_readback #(.PRIO_W(PRIO_W)) u_rb (
        .rd_sel  (rd_sel),
        .pm      (pm_q),
        .fm      (fm_q),
        .bp      (bp_q),
        .rd_data (rd_data)
    );

    always_comb begin
        allow_d = 1'b0;
        if (req_valid) begin
            unique case (cls)
                CLS_NMI:  allow_d = 1'b1;
                CLS_HARD: allow_d = ~fm_q & ~prio_blocked;
                default:  allow_d = ~pm_q & ~fm_q & ~prio_blocked;
            endcase
        end
    end

    assign allow    = allow_d;
    assign pass_num = allow_d ? req_num : '0;
    assign pri_mask = pm_q;
    assign flt_mask = fm_q;
    assign base_pri = bp_q;

endmodule

// File: rtl/exc_mask_filter_chk.sv
module exc_mask_filter_chk #(
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned NUM_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_cls,
    input logic [PRIO_W-1:0] req_prio,
    input logic              wr_en,
    input logic              priv_lvl,
    input logic              allow,
    input logic [NUM_W-1:0]  pass_num,
    input logic              pri_mask,
    input logic              flt_mask,
    input logic [PRIO_W-1:0] base_pri
);

    AST_NMI_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cls == 2'd0) |-> allow); // R2

    AST_PRI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_mask && req_cls[1]) |-> !allow); // R3

    AST_FLT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_mask && req_cls != 2'd0) |-> !allow); // R4

    AST_BASE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (base_pri != '0 && req_prio >= base_pri && req_cls != 2'd0) |-> !allow); // R5

    AST_USER_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !priv_lvl) |=> ($stable(pri_mask) && $stable(flt_mask) && $stable(base_pri))); // R7

    AST_IDLE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !allow); // R10

    AST_PASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |-> (pass_num == '0)); // R11

endmodule

bind exc_mask_filter exc_mask_filter_chk #(.PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cls   (req_cls),
    .req_prio  (req_prio),
    .wr_en     (wr_en),
    .priv_lvl  (priv_lvl),
    .allow     (allow),
    .pass_num  (pass_num),
    .pri_mask  (pri_mask),
    .flt_mask  (flt_mask),
    .base_pri  (base_pri)
);

// File: tb/tb_exc_mask_filter.sv
`timescale 1ns/1ps
module tb_exc_mask_filter;

    localparam int unsigned PRIO_W = 8;
    localparam int unsigned NUM_W  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [NUM_W-1:0]  req_num = '0;
    logic [1:0]        req_cls = 2'd0;
    logic [PRIO_W-1:0] req_prio = '0;
    logic              wr_en = 1'b0;
    logic              priv_lvl = 1'b0;
    logic [1:0]        wr_sel = 2'd0;
    logic [PRIO_W-1:0] wr_data = '0;
    logic [1:0]        rd_sel = 2'd0;
    logic [PRIO_W-1:0] rd_data;
    logic              allow;
    logic [NUM_W-1:0]  pass_num;
    logic              pri_mask, flt_mask;
    logic [PRIO_W-1:0] base_pri;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // shadow of the mask registers
    logic              m_pm = 1'b0, m_fm = 1'b0;
    logic [PRIO_W-1:0] m_bp = '0;

    always #5 clk = ~clk;

    exc_mask_filter #(.PRIO_W(PRIO_W), .NUM_W(NUM_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
        .req_cls(req_cls), .req_prio(req_prio), .wr_en(wr_en), .priv_lvl(priv_lvl),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .allow(allow), .pass_num(pass_num), .pri_mask(pri_mask),
        .flt_mask(flt_mask), .base_pri(base_pri)
    );

    function automatic logic exp_allow(logic v, logic [1:0] c, logic [PRIO_W-1:0] p);
        logic pblk;
        pblk = (m_bp != '0) && (p >= m_bp);
        if (!v) return 1'b0;
        case (c)
            2'd0:    return 1'b1;
            2'd1:    return !m_fm && !pblk;
            default: return !m_pm && !m_fm && !pblk;
        endcase
    endfunction

    function automatic logic [PRIO_W-1:0] exp_rd(logic [1:0] s);
        case (s)
            2'd0:    return {{(PRIO_W-1){1'b0}}, m_pm};
            2'd1:    return {{(PRIO_W-1){1'b0}}, m_fm};
            2'd2:    return m_bp;
            default: return '0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(logic pv, logic [1:0] s, logic [PRIO_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; priv_lvl = pv; wr_sel = s; wr_data = d;
        @(posedge clk);
        if (pv) begin
            case (s)
                2'd0: m_pm = d[0];
                2'd1: m_fm = d[0];
                2'd2: m_bp = d;
                default: ;
            endcase
        end
        #1 wr_en = 1'b0;
    endtask

    task automatic check_regs(string req);
        @(negedge clk);
        check({req, " pri_mask"}, 32'(pri_mask), 32'(m_pm));
        check({req, " flt_mask"}, 32'(flt_mask), 32'(m_fm));
        check({req, " base_pri"}, 32'(base_pri), 32'(m_bp));
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            check({req, " R9 rd_data"}, 32'(rd_data), 32'(exp_rd(2'(s))));
        end
    endtask

    task automatic do_req(string req, logic v, logic [1:0] c, logic [PRIO_W-1:0] p,
                          logic [NUM_W-1:0] n);
        logic e;
        @(negedge clk);
        req_valid = v; req_cls = c; req_prio = p; req_num = n;
        #1;
        e = exp_allow(v, c, p);
        check({req, " allow"}, 32'(allow), 32'(e));
        check({req, " R11 pass_num"}, 32'(pass_num), e ? 32'(n) : 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check_regs("R1");
        do_req("R1 R6 irq unmasked", 1'b1, 2'd3, 8'hFF, 9'd40);
        do_req("R10 no valid", 1'b0, 2'd0, 8'h00, 9'd2);

        // R7: user writes ignored
        do_write(1'b0, 2'd0, 8'h01);
        do_write(1'b0, 2'd1, 8'h01);
        do_write(1'b0, 2'd2, 8'h40);
        check_regs("R7");
        do_req("R7 irq after user writes", 1'b1, 2'd3, 8'h80, 9'd17);

        // R3 primary mask
        do_write(1'b1, 2'd0, 8'hFF);
        check_regs("R8 R12 pri");
        do_req("R3 irq blocked", 1'b1, 2'd3, 8'h00, 9'd20);
        do_req("R3 fault blocked", 1'b1, 2'd2, 8'h00, 9'd4);
        do_req("R3 hard passes", 1'b1, 2'd1, 8'h00, 9'd3);
        do_req("R2 nmi pri", 1'b1, 2'd0, 8'hFF, 9'd2);

        // R4 fault mask
        do_write(1'b1, 2'd1, 8'h03);
        do_req("R4 hard blocked", 1'b1, 2'd1, 8'h00, 9'd3);
        do_req("R2 nmi flt", 1'b1, 2'd0, 8'h00, 9'd2);
        do_write(1'b1, 2'd0, 8'h00);
        do_write(1'b1, 2'd1, 8'hFE);  // bit0 = 0 clears
        check_regs("R8 clear");

        // R5 threshold boundaries
        do_write(1'b1, 2'd2, 8'h40);
        check_regs("R8 base");
        do_req("R5 prio equal", 1'b1, 2'd3, 8'h40, 9'd30);
        do_req("R5 prio one below", 1'b1, 2'd3, 8'h3F, 9'd30);
        do_req("R5 prio above", 1'b1, 2'd2, 8'hC0, 9'd5);
        do_req("R5 hard equal", 1'b1, 2'd1, 8'h40, 9'd3);
        do_req("R2 nmi base", 1'b1, 2'd0, 8'hFF, 9'd2);
        do_write(1'b1, 2'd3, 8'h00);  // sel 3 changes nothing
        check_regs("R8 sel3");
        do_write(1'b1, 2'd2, 8'h00);
        do_req("R6 zero thresh prio0", 1'b1, 2'd3, 8'h00, 9'd60);
        do_req("R6 zero thresh prioFF", 1'b1, 2'd2, 8'hFF, 9'd6);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom % 4;
            if (r == 0) begin
                logic [PRIO_W-1:0] d;
                d = ($urandom % 2) ? PRIO_W'($urandom % 6) : PRIO_W'($urandom);
                do_write(logic'($urandom % 2), 2'($urandom % 4), d);
                check_regs("R7 R8 R12 random");
            end else begin
                logic [PRIO_W-1:0] p;
                p = ($urandom % 2) ? PRIO_W'($urandom % 6) : PRIO_W'($urandom);
                do_req("R2 R3 R4 R5 R10 random", logic'(($urandom % 8) != 0),
                       2'($urandom % 4), p, NUM_W'($urandom));
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule